// File: doc/BRIEF.md
# Verified Chip-Erase Sequencer

This block is a host-side controller that takes a command-driven flash array from any state to fully erased and checked. After a start pulse it raises the program-voltage enable, asks a companion program sequencer to write 0000h into every word (this makes the later erasure uniform), and waits for that sequencer to report completion. It then alternates erase pulses with word-by-word verification over a simple synchronous bus. On this bus the sequencer drives a write or a read strobe for one cycle, and read data is returned one cycle after the read strobe.

An erase pulse is two writes of the erase command 0020h followed by a fixed settling wait. Verification of one word writes the verify command 00A0h with that word's address, waits a shorter margin time and then reads the word back. The word passes if every bit is set. A passing word advances the address. A failing word triggers another erase pulse, after which verification continues at the same failing word instead of at address zero. The number of erase pulses is capped. When the last word passes, the controller writes the read command 0000h, drops the voltage enable and reports pass. When the cap is exhausted, it drops the enable and reports fail.

The states are:
- ST_IDLE: waiting, results held.
- ST_PREP_KICK: pulse to the program sequencer.
- ST_PREP_WAIT: waiting for it to finish.
- ST_ERS_SETUP: first erase write.
- ST_ERS_GO: second erase write.
- ST_ERS_WAIT: erase settling.
- ST_VFY_CMD: verify command.
- ST_VFY_WAIT: margin wait.
- ST_VFY_READ: read strobe.
- ST_VFY_CHECK: compare.
- ST_READ_CMD: closing read command.

The transitions are:
- IDLE→PREP_KICK on start.
- PREP_KICK→PREP_WAIT.
- PREP_WAIT→ERS_SETUP on completion.
- ERS_SETUP→ERS_GO→ERS_WAIT.
- ERS_WAIT→VFY_CMD on timer expiry.
- VFY_CMD→VFY_WAIT.
- VFY_WAIT→VFY_READ on expiry.
- VFY_READ→VFY_CHECK.
- VFY_CHECK→VFY_CMD on a pass that is not the last word.
- VFY_CHECK→READ_CMD on a pass at the last word.
- VFY_CHECK→ERS_SETUP on a fail below the cap.
- VFY_CHECK→IDLE on a fail at the cap.
- READ_CMD→IDLE.

Top module: `chip_erase_seq`

## Requirements
- R1: While reset is asserted and afterwards until a start, vpp_en, done, pass, prog_start, bus_wr and bus_rd are all 0.
- R2: A start seen in the idle state clears done and pass, raises vpp_en, and gives prog_start as a single-cycle pulse in the following cycle; no bus strobe occurs until prog_done has been seen.
- R3: Each erase pulse is two consecutive write cycles with data 0020h, after which the bus stays quiet for exactly ERASE_CYC cycles, so the next write comes ERASE_CYC+1 cycles after the second erase write.
- R4: Each word check writes data 00A0h at the word's address, leaves exactly VERIFY_CYC quiet cycles, then issues a read of the same address; bus_rdata is compared in the cycle after the read strobe.
- R5: Verification starts at address 0 after every start, and a word that reads all ones moves the check to the next address.
- R6: A word that does not read all ones while fewer than PULSE_LIMIT erase pulses have been issued causes a new erase pulse, after which verification resumes at that same word; earlier words are not read again.
- R7: A failing word after PULSE_LIMIT erase pulses ends the run with no further bus cycle: vpp_en falls and done=1 with pass=0. A run that needs exactly PULSE_LIMIT pulses still passes.
- R8: After the last address reads all ones, one write with data 0000h is issued, after which vpp_en falls and done=1 with pass=1.
- R9: done and pass keep their values, and vpp_en stays 0, until the next start.
- R10: bus_wr and bus_rd are never both high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a full erase run (accepted when idle) |
| prog_start | output | 1 | One-cycle request to the program sequencer to write 0000h everywhere |
| prog_done | input | 1 | Program sequencer finished |
| bus_wr | output | 1 | Write strobe, one cycle per write |
| bus_rd | output | 1 | Read strobe, one cycle per read |
| bus_addr | output | ADDR_W | Word address |
| bus_wdata | output | DATA_W | Write data (command code) |
| bus_rdata | input | DATA_W | Read data, valid the cycle after bus_rd |
| vpp_en | output | 1 | Program-voltage enable, high during a run |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | Run result, valid while done is high |

## Verification
prog_start is due one cycle after the start cycle. A verify write follows the second erase write by ERASE_CYC+1 cycles, and a read follows its verify write by VERIFY_CYC+1 cycles. The word is compared one cycle after the read, and the next strobe comes one cycle after that. done rises one cycle after the final 0000h write, or one cycle after the failing compare. The bench samples every signal on the falling edge, stamps each strobe with a rising-edge cycle count and checks these gaps directly. Its flash model answers reads one rising edge after the strobe, the same latency the sequencer assumes. The expected strobe stream is computed in advance from each word's required pulse count and compared in order, so a missing, extra or reordered cycle is reported where it happens.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    localparam logic [15:0] CMD_ERASE  = 16'h0020;
    localparam logic [15:0] CMD_VERIFY = 16'h00A0;
    localparam logic [15:0] CMD_READ   = 16'h0000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREP_KICK,
        ST_PREP_WAIT,
        ST_ERS_SETUP,
        ST_ERS_GO,
        ST_ERS_WAIT,
        ST_VFY_CMD,
        ST_VFY_WAIT,
        ST_VFY_READ,
        ST_VFY_CHECK,
        ST_READ_CMD
    } ers_state_e;

endpackage

// File: rtl/seq_wait_timer.sv
// Down-counting wait timer: load N-1, expired once it reaches zero.
module seq_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/seq_up_counter.sv
// Clearable up-counter used for the word address and the pulse tally.
module seq_up_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int ERASE_CYC   = 2_000_000,
    parameter int VERIFY_CYC  = 1200,
    parameter int PULSE_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              prog_start,
    input  logic              prog_done,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              vpp_en,
    output logic              done,
    output logic              pass
);
    localparam int LONGEST = (ERASE_CYC > VERIFY_CYC) ? ERASE_CYC : VERIFY_CYC;
    localparam int TMR_W   = $clog2(LONGEST + 1);
    localparam int PCNT_W  = $clog2(PULSE_LIMIT + 1);

    ers_state_e state_q, state_d;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              run_clr;
    logic              addr_inc;
    logic              pulse_inc;
    logic [ADDR_W-1:0] word_addr;
    logic [PCNT_W-1:0] pulse_cnt;
    logic              fin_pass;
    logic              fin_fail;
    logic              word_erased;
    logic              word_last;
    logic              cap_hit;

    seq_wait_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    seq_up_counter #(.W(ADDR_W)) u_addr_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (run_clr),
        .inc   (addr_inc),
        .cnt   (word_addr)
    );

    seq_up_counter #(.W(PCNT_W)) u_pulse_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (run_clr),
        .inc   (pulse_inc),
        .cnt   (pulse_cnt)
    );

    assign word_erased = (bus_rdata == {DATA_W{1'b1}});
    assign word_last   = (word_addr == {ADDR_W{1'b1}});
    assign cap_hit     = (pulse_cnt == PCNT_W'(PULSE_LIMIT));

    // State register and held results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            pass    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (run_clr) begin
                done <= 1'b0;
                pass <= 1'b0;
            end else if (fin_pass || fin_fail) begin
                done <= 1'b1;
                pass <= fin_pass;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        prog_start = 1'b0;
        bus_wr     = 1'b0;
        bus_rd     = 1'b0;
        bus_addr   = word_addr;
        bus_wdata  = '0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        run_clr    = 1'b0;
        addr_inc   = 1'b0;
        pulse_inc  = 1'b0;
        fin_pass   = 1'b0;
        fin_fail   = 1'b0;
        vpp_en     = (state_q != ST_IDLE);

        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    run_clr = 1'b1;
                    state_d = ST_PREP_KICK;
                end
            end
            ST_PREP_KICK: begin
                prog_start = 1'b1;
                state_d    = ST_PREP_WAIT;
            end
            ST_PREP_WAIT: begin
                if (prog_done) state_d = ST_ERS_SETUP;
            end
            ST_ERS_SETUP: begin
                bus_wr    = 1'b1;
                bus_wdata = DATA_W'(CMD_ERASE);
                state_d   = ST_ERS_GO;
            end
            ST_ERS_GO: begin
                bus_wr    = 1'b1;
                bus_wdata = DATA_W'(CMD_ERASE);
                pulse_inc = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(ERASE_CYC - 1);
                state_d   = ST_ERS_WAIT;
            end
            ST_ERS_WAIT: begin
                if (tmr_expired) state_d = ST_VFY_CMD;
            end
            ST_VFY_CMD: begin
                bus_wr    = 1'b1;
                bus_wdata = DATA_W'(CMD_VERIFY);
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(VERIFY_CYC - 1);
                state_d   = ST_VFY_WAIT;
            end
            ST_VFY_WAIT: begin
                if (tmr_expired) state_d = ST_VFY_READ;
            end
            ST_VFY_READ: begin
                bus_rd  = 1'b1;
                state_d = ST_VFY_CHECK;
            end
            ST_VFY_CHECK: begin
                if (word_erased) begin
                    if (word_last) begin
                        state_d = ST_READ_CMD;
                    end else begin
                        addr_inc = 1'b1;
                        state_d  = ST_VFY_CMD;
                    end
                end else if (cap_hit) begin
                    fin_fail = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    state_d = ST_ERS_SETUP;
                end
            end
            ST_READ_CMD: begin
                bus_wr    = 1'b1;
                bus_wdata = DATA_W'(CMD_READ);
                fin_pass  = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/erase_seq_checker.sv
module erase_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic prog_start,
    input logic bus_wr,
    input logic bus_rd,
    input logic vpp_en,
    input logic done,
    input logic pass
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R10

    AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start); // R2

    AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> (!bus_wr && !bus_rd)); // R2

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass))); // R9

    AST_DONE_VPP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !vpp_en); // R7

    AST_DONE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_wr && !bus_rd)); // R8

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && vpp_en)); // R2
endmodule

bind chip_erase_seq erase_seq_checker u_erase_seq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .prog_start (prog_start),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .vpp_en     (vpp_en),
    .done       (done),
    .pass       (pass)
);

// File: tb/test_chip_erase_seq.sv
`timescale 1ns/1ps
module test_chip_erase_seq;
    localparam int AW = 3;
    localparam int DW = 16;
    localparam int EC = 5;
    localparam int VC = 3;
    localparam int LIM = 4;
    localparam int WORDS = 1 << AW;

    typedef struct packed {
        logic          is_rd;
        logic [DW-1:0] data;
        logic [AW-1:0] addr;
        logic          chk_addr;
    } bus_op_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic prog_done = 1'b0;
    logic prog_start, bus_wr, bus_rd, vpp_en, done, pass;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;

    always #2.5 clk = ~clk;

    chip_erase_seq #(
        .ADDR_W(AW), .DATA_W(DW), .ERASE_CYC(EC),
        .VERIFY_CYC(VC), .PULSE_LIMIT(LIM)
    ) i_chip_erase_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .prog_start(prog_start), .prog_done(prog_done),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .vpp_en(vpp_en), .done(done), .pass(pass)
    );

    int n_tests = 0;
    int n_fail = 0;
    bus_op_t exp_q[$];
    int need [WORDS];
    int erase_writes = 0;
    int cyc = 0;
    bit prep_busy = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Flash model: a word reads all ones once it has had enough erase pulses
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bus_wr && bus_wdata == 16'h0020) erase_writes <= erase_writes + 1;
        if (bus_rd)
            bus_rdata <= ((erase_writes / 2) >= need[bus_addr]) ? 16'hFFFF : 16'h0000;
    end

    // Program sequencer model
    initial begin
        forever begin
            @(negedge clk);
            if (prog_start) begin
                prep_busy = 1'b1;
                repeat (4) @(negedge clk);
                prog_done = 1'b1;
                @(negedge clk);
                prog_done = 1'b0;
                prep_busy = 1'b0;
            end
        end
    end

    // Monitor: pop and compare every strobe, check timing gaps
    initial begin
        bus_op_t prev;
        int prev_cyc;
        bit have_prev;
        have_prev = 1'b0;
        prev = '0;
        prev_cyc = 0;
        forever begin
            @(negedge clk);
            if (bus_wr || bus_rd) begin
                bus_op_t e;
                chk(!(bus_wr && bus_rd), "R10 strobe overlap", 1, 0);
                chk(!prep_busy, "R2 bus quiet before prog_done", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected bus cycle", int'(bus_wdata), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(bus_rd == e.is_rd, "R4 strobe kind", int'(bus_rd), int'(e.is_rd));
                    if (!e.is_rd)
                        chk(bus_wdata == e.data, "R3 write data", int'(bus_wdata), int'(e.data));
                    if (e.chk_addr)
                        chk(bus_addr == e.addr, "R6 verify address", int'(bus_addr), int'(e.addr));
                end
                if (have_prev && !prev.is_rd && prev.data == 16'h0020 && bus_wr && bus_wdata == 16'h00A0)
                    chk(cyc - prev_cyc == EC + 1, "R3 erase wait", cyc - prev_cyc, EC + 1);
                if (have_prev && !prev.is_rd && prev.data == 16'h00A0 && bus_rd)
                    chk(cyc - prev_cyc == VC + 1, "R4 verify wait", cyc - prev_cyc, VC + 1);
                prev.is_rd = bus_rd;
                prev.data = bus_wdata;
                prev_cyc = cyc;
                have_prev = 1'b1;
            end
        end
    end

    // Driver: build expected strobe stream from the requirements
    task automatic plan(output bit exp_pass);
        int p = 0;
        int a = 0;
        bit over = 1'b0;
        exp_pass = 1'b0;
        while (!over) begin
            p++;
            exp_q.push_back('{1'b0, 16'h0020, '0, 1'b0});
            exp_q.push_back('{1'b0, 16'h0020, '0, 1'b0});
            forever begin
                exp_q.push_back('{1'b0, 16'h00A0, AW'(a), 1'b1});
                exp_q.push_back('{1'b1, 16'h0000, AW'(a), 1'b1});
                if (p >= need[a]) begin
                    if (a == WORDS - 1) begin
                        exp_q.push_back('{1'b0, 16'h0000, '0, 1'b0});
                        exp_pass = 1'b1;
                        over = 1'b1;
                        break;
                    end
                    a++;
                end else begin
                    if (p == LIM) over = 1'b1;
                    break;
                end
            end
        end
    endtask

    task automatic run(input string tag);
        bit exp_pass;
        int guard;
        erase_writes = 0;
        plan(exp_pass);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(prog_start == 1'b1, {tag, " R2 prog_start pulse"}, int'(prog_start), 1);
        chk(vpp_en == 1'b1 && done == 1'b0, {tag, " R2 vpp_en up, done cleared"}, int'({vpp_en, done}), 2);
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1, {tag, " R8 done"}, int'(done), 1);
        chk(pass == exp_pass, exp_pass ? {tag, " R8 pass"} : {tag, " R7 fail"}, int'(pass), int'(exp_pass));
        chk(vpp_en == 1'b0, {tag, " R7 vpp_en dropped"}, int'(vpp_en), 0);
        chk(exp_q.size() == 0, {tag, " R5 all cycles issued"}, exp_q.size(), 0);
        exp_q.delete();
        repeat (10) @(negedge clk);
        chk(done == 1'b1 && pass == exp_pass && vpp_en == 1'b0, {tag, " R9 results held"},
            int'({done, pass, vpp_en}), int'({1'b1, exp_pass, 1'b0}));
    endtask

    initial begin
        foreach (need[i]) need[i] = 1;
        repeat (3) @(negedge clk);
        chk({vpp_en, done, pass, prog_start, bus_wr, bus_rd} == 6'b0, "R1 in reset",
            int'({vpp_en, done, pass, prog_start, bus_wr, bus_rd}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({vpp_en, done, pass, prog_start, bus_wr, bus_rd} == 6'b0, "R1 after reset",
            int'({vpp_en, done, pass, prog_start, bus_wr, bus_rd}), 0);

        run("single pulse R5");

        foreach (need[i]) need[i] = 1;
        need[3] = 2; need[6] = 3;
        run("resume R6");

        foreach (need[i]) need[i] = 1;
        need[7] = LIM;
        run("limit boundary R7");

        foreach (need[i]) need[i] = 1;
        need[5] = LIM + 1;
        run("limit exceeded R7");

        foreach (need[i]) need[i] = 2;
        run("restart after fail R2");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule